// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block sits between a host bus and the storage array of a NOR flash model. It watches bus write cycles, decodes the command byte in the low eight data bits, and runs the resulting operation on a small internal word array. Supported operations are single-word program, buffered multi-word program, block erase, erase suspend with resume, clearing of the status flags, and selection of what the read path returns. Programming and erasing take a fixed number of clock cycles, and the ready flag is low while they run. A program can only turn 1 bits into 0 bits. An erase writes all ones into every word of one block.

The host reads through a combinational port. In array mode the port returns the stored word. In status mode it returns the status byte zero-extended to 16 bits. In identifier mode it returns two fixed code words. In query mode it returns the three ASCII letters of a query signature. The status byte is also available on its own output. Error flags stay set until the host clears them, and a clear request is only honoured when no operation is running. A block-lock vector and a programming-voltage-good input guard every program and erase.

Top module: `nor_cmd_engine`

## Requirements
- R1: After reset the status byte is 0x80, the read mode is array (encoding 0), and every array word reads 0xFFFF.
- R2: Writing 0x40 or 0x10, followed by one data write, starts a word program. The ready bit (status bit 7) is 0 from the cycle after the data write until the program ends. Afterwards the word holds its old value AND the written data, so bits only go from 1 to 0.
- R3: Writing 0x20 followed by 0xD0 to an address in the same block sets all 32 words of that block to 0xFFFF. No other block changes.
- R4: If the second write after 0x20 is not 0xD0, or goes to a different block, nothing is erased. Both the erase-error bit (bit 5) and the program-error bit (bit 4) are set.
- R5: A buffered program has four parts: 0xE8, then a count equal to the word total minus one (at most 31), then that many data writes, then 0xD0. Every loaded word is then ANDed into the array at its address. If one slot is written twice, the last write wins.
- R6: Buffered program errors change no array word. A count above 31 sets bits 5 and 4. A data address outside the 32-word aligned region of the start address sets bit 4 at confirm. A final code other than 0xD0 sets bits 5 and 4.
- R7: 0xFF selects array read (0). 0x70 selects status read (1) and returns the status byte on bits 7:0. 0x90 selects identifier read (2): offset 0 returns 0x00A5 and offset 1 returns 0x5A3C. 0x98 selects query read (3): offsets 0x10, 0x11 and 0x12 return 0x51, 0x52 and 0x59.
- R8: Any program, buffered-program or erase setup command switches the read mode to status.
- R9: If the voltage-good input is low, a program sets bits 3 and 4 and an erase sets bits 3 and 5. If the target block is locked, the operation sets bit 1 together with its own error bit. In both cases the array is unchanged.
- R10: 0x50 clears bits 5, 4, 3 and 1 when the ready bit is 1. Written while an operation is running, it has no effect.
- R11: Error bits stay set through later successful operations and through an erase resume until they are cleared.
- R12: 0xB0 during an erase stops it within one cycle, with ready and erase-suspended (bit 6) both set. While the erase is suspended, a program to another block runs normally, and a program to the suspended block sets bit 4 and changes nothing. 0xD0 then resumes the erase, which completes.
- R13: 0xD0 with no erase suspended is ignored: read mode and status do not change. 0xB0 during a program is ignored, and the program completes.
- R14: While an operation runs, every command except 0x70 and 0xB0 leaves the read mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Bus write strobe, one cycle per write |
| wrAddr | input | 8 | Word address of the write |
| wrData | input | 16 | Write data; command code in bits 7:0 |
| rdAddr | input | 8 | Word address for the read path |
| rdData | output | 16 | Read data selected by the read mode |
| readMode | output | 2 | Current read mode: 0 array, 1 status, 2 identifier, 3 query |
| status | output | 8 | Status byte |
| vppOk | input | 1 | Programming voltage good |
| blockLock | input | 8 | One lock bit per 32-word block |

## Verification
The bench targets the cases a sequencer most often gets wrong.

- **Reprogramming with ones.** A design that writes data instead of ANDing it would bring erased bits back.
- **Suspend that does not stop.** A design that keeps erasing after the suspend command would reach words that should still hold their programmed value.
- **Program into the suspended block.** A design that accepts it would change the suspended block.
- **Clear while busy.** A design that honours it would lose error flags that should survive.
- **Resume with nothing suspended.** A design that reacts would change the read mode or the status.
- **Buffered-program abort paths.** A design that gets these wrong would program the array despite a bad count or a bad address.

Random word, block and buffered programs run between these directed cases, and a shadow array checks every read.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;
  localparam int ADDR_W    = 8;
  localparam int DATA_W    = 16;
  localparam int BLK_W     = 5;
  localparam int BUF_W     = 5;
  localparam int BLKID_W   = ADDR_W - BLK_W;
  localparam int BUFID_W   = ADDR_W - BUF_W;
  localparam int BLK_NUM   = 1 << BLKID_W;
  localparam int BUF_DEPTH = 1 << BUF_W;
  localparam int MEM_DEPTH = 1 << ADDR_W;

  localparam logic [7:0] CMD_PROG     = 8'h40;
  localparam logic [7:0] CMD_PROG_ALT = 8'h10;
  localparam logic [7:0] CMD_ERASE    = 8'h20;
  localparam logic [7:0] CMD_CONFIRM  = 8'hD0;
  localparam logic [7:0] CMD_BUFPROG  = 8'hE8;
  localparam logic [7:0] CMD_ARRAY    = 8'hFF;
  localparam logic [7:0] CMD_STATUS   = 8'h70;
  localparam logic [7:0] CMD_IDENT    = 8'h90;
  localparam logic [7:0] CMD_QUERY    = 8'h98;
  localparam logic [7:0] CMD_CLEAR    = 8'h50;
  localparam logic [7:0] CMD_SUSPEND  = 8'hB0;

  typedef enum logic [1:0] {
    RM_ARRAY  = 2'd0,
    RM_STATUS = 2'd1,
    RM_IDENT  = 2'd2,
    RM_QUERY  = 2'd3
  } rdmode_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PG_SETUP, ST_PG_BUSY, ST_ER_SETUP, ST_ER_BUSY,
    ST_BP_COUNT, ST_BP_LOAD, ST_BP_CONFIRM, ST_BP_BUSY
  } state_e;

  typedef struct packed {
    logic              progWr;
    logic              eraseWr;
    logic              bufClr;
    logic              bufWr;
    logic              bufCommit;
    logic [BUF_W-1:0]  bufIdx;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } strobe_t;
endpackage

// File: rtl/nor_cmd_ctrl.sv
module nor_cmd_ctrl
  import nor_cmd_pkg::*;
#(
  parameter int PROG_CYC = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              vppOk,
  input  logic [BLK_NUM-1:0] blockLock,
  output strobe_t           st,
  output rdmode_e           readMode,
  output logic [7:0]        status
);
  localparam int CNT_W = $clog2(PROG_CYC + 1);

  state_e              state;
  logic                erErr, pgErr, vppErr, lockErr, eraseSusp;
  logic [ADDR_W-1:0]   tgtAddr;
  logic [DATA_W-1:0]   tgtData;
  logic [BLKID_W-1:0]  setupBlk, eraseBlk;
  logic [BLK_W-1:0]    eIdx;
  logic [BUFID_W-1:0]  bufBase;
  logic [BUF_W-1:0]    bIdx;
  logic [BUF_W:0]      bpRemain;
  logic                bpBad;
  logic [CNT_W-1:0]    cnt;

  logic [7:0]          cmd;
  logic [BLKID_W-1:0]  wrBlk, bufBlk;
  logic                busy, suspendReq;

  assign cmd        = wrData[7:0];
  assign wrBlk      = wrAddr[ADDR_W-1:BLK_W];
  assign bufBlk     = BLKID_W'(bufBase >> (BLK_W - BUF_W));
  assign busy       = (state == ST_PG_BUSY) || (state == ST_ER_BUSY) || (state == ST_BP_BUSY);
  assign suspendReq = (state == ST_ER_BUSY) && wrEn && (cmd == CMD_SUSPEND);
  assign status     = {!busy, eraseSusp, erErr, pgErr, vppErr, 1'b0, lockErr, 1'b0};

  always_comb begin
    st = '0;
    case (state)
      ST_PG_BUSY: begin
        st.progWr = (cnt == '0);
        st.addr   = tgtAddr;
        st.data   = tgtData;
      end
      ST_ER_BUSY: begin
        st.eraseWr = !suspendReq;
        st.addr    = {eraseBlk, eIdx};
      end
      ST_BP_LOAD: begin
        st.bufWr  = wrEn;
        st.bufIdx = wrAddr[BUF_W-1:0];
        st.data   = wrData;
      end
      ST_BP_BUSY: begin
        st.bufCommit = 1'b1;
        st.bufIdx    = bIdx;
        st.addr      = {bufBase, bIdx};
      end
      ST_IDLE: st.bufClr = wrEn && (cmd == CMD_BUFPROG);
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      readMode  <= RM_ARRAY;
      erErr     <= 1'b0;
      pgErr     <= 1'b0;
      vppErr    <= 1'b0;
      lockErr   <= 1'b0;
      eraseSusp <= 1'b0;
      tgtAddr   <= '0;
      tgtData   <= '0;
      setupBlk  <= '0;
      eraseBlk  <= '0;
      eIdx      <= '0;
      bufBase   <= '0;
      bIdx      <= '0;
      bpRemain  <= '0;
      bpBad     <= 1'b0;
      cnt       <= '0;
    end else begin
      if (busy && wrEn && (cmd == CMD_STATUS)) readMode <= RM_STATUS;
      case (state)
        ST_IDLE: if (wrEn) begin
          case (cmd)
            CMD_PROG, CMD_PROG_ALT: begin
              state    <= ST_PG_SETUP;
              readMode <= RM_STATUS;
            end
            CMD_ERASE: begin
              state    <= ST_ER_SETUP;
              setupBlk <= wrBlk;
              readMode <= RM_STATUS;
            end
            CMD_BUFPROG: begin
              state    <= ST_BP_COUNT;
              bufBase  <= wrAddr[ADDR_W-1:BUF_W];
              bpBad    <= 1'b0;
              readMode <= RM_STATUS;
            end
            CMD_ARRAY:  readMode <= RM_ARRAY;
            CMD_STATUS: readMode <= RM_STATUS;
            CMD_IDENT:  readMode <= RM_IDENT;
            CMD_QUERY:  readMode <= RM_QUERY;
            CMD_CLEAR: begin
              erErr   <= 1'b0;
              pgErr   <= 1'b0;
              vppErr  <= 1'b0;
              lockErr <= 1'b0;
            end
            CMD_CONFIRM: if (eraseSusp) begin
              state     <= ST_ER_BUSY;
              eraseSusp <= 1'b0;
              readMode  <= RM_STATUS;
            end
            default: ;
          endcase
        end
        ST_PG_SETUP: if (wrEn) begin
          state <= ST_IDLE;
          if (!vppOk) begin
            vppErr <= 1'b1;
            pgErr  <= 1'b1;
          end else if (blockLock[wrBlk]) begin
            lockErr <= 1'b1;
            pgErr   <= 1'b1;
          end else if (eraseSusp && (wrBlk == eraseBlk)) begin
            pgErr <= 1'b1;
          end else begin
            tgtAddr <= wrAddr;
            tgtData <= wrData;
            cnt     <= CNT_W'(PROG_CYC - 1);
            state   <= ST_PG_BUSY;
          end
        end
        ST_ER_SETUP: if (wrEn) begin
          state <= ST_IDLE;
          if ((cmd != CMD_CONFIRM) || (wrBlk != setupBlk) || eraseSusp) begin
            erErr <= 1'b1;
            pgErr <= 1'b1;
          end else if (!vppOk) begin
            vppErr <= 1'b1;
            erErr  <= 1'b1;
          end else if (blockLock[wrBlk]) begin
            lockErr <= 1'b1;
            erErr   <= 1'b1;
          end else begin
            eraseBlk <= wrBlk;
            eIdx     <= '0;
            state    <= ST_ER_BUSY;
          end
        end
        ST_BP_COUNT: if (wrEn) begin
          if (wrData > DATA_W'(BUF_DEPTH - 1)) begin
            erErr <= 1'b1;
            pgErr <= 1'b1;
            state <= ST_IDLE;
          end else begin
            bpRemain <= {1'b0, wrData[BUF_W-1:0]} + 1'b1;
            state    <= ST_BP_LOAD;
          end
        end
        ST_BP_LOAD: if (wrEn) begin
          if (wrAddr[ADDR_W-1:BUF_W] != bufBase) bpBad <= 1'b1;
          bpRemain <= bpRemain - 1'b1;
          if (bpRemain == (BUF_W+1)'(1)) state <= ST_BP_CONFIRM;
        end
        ST_BP_CONFIRM: if (wrEn) begin
          state <= ST_IDLE;
          if (cmd != CMD_CONFIRM) begin
            erErr <= 1'b1;
            pgErr <= 1'b1;
          end else if (bpBad) begin
            pgErr <= 1'b1;
          end else if (!vppOk) begin
            vppErr <= 1'b1;
            pgErr  <= 1'b1;
          end else if (blockLock[bufBlk]) begin
            lockErr <= 1'b1;
            pgErr   <= 1'b1;
          end else if (eraseSusp && (bufBlk == eraseBlk)) begin
            pgErr <= 1'b1;
          end else begin
            bIdx  <= '0;
            state <= ST_BP_BUSY;
          end
        end
        ST_PG_BUSY: begin
          if (cnt == '0) state <= ST_IDLE;
          else cnt <= cnt - 1'b1;
        end
        ST_ER_BUSY: begin
          if (suspendReq) begin
            eraseSusp <= 1'b1;
            state     <= ST_IDLE;
          end else if (eIdx == '1) begin
            state <= ST_IDLE;
          end else begin
            eIdx <= eIdx + 1'b1;
          end
        end
        ST_BP_BUSY: begin
          if (bIdx == '1) state <= ST_IDLE;
          else bIdx <= bIdx + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R11: erase-error flag persists until a clear command is written
  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (erErr && !(wrEn && cmd == CMD_CLEAR)) |=> erErr);

  // R10: clear written while running leaves every error flag as it was
  a_r10_clear_busy_noeffect: assert property (@(posedge clk) disable iff (!rstN)
    (busy && wrEn && cmd == CMD_CLEAR) |=>
      ({erErr, pgErr, vppErr, lockErr} == $past({erErr, pgErr, vppErr, lockErr})));

  // R12: suspend during erase gives ready and suspended on the next cycle
  a_r12_suspend_ready: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ER_BUSY && wrEn && cmd == CMD_SUSPEND) |=> (status[7] && status[6]));

  // R13: resume without a suspended erase changes nothing visible
  a_r13_resume_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !eraseSusp && wrEn && cmd == CMD_CONFIRM) |=>
      ($stable(readMode) && status[7]));

  // R14: while running, only the status command may change the read mode
  a_r14_busy_mode_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busy && wrEn && cmd != CMD_STATUS) |=> $stable(readMode));
endmodule

// File: rtl/nor_cmd_datapath.sv
module nor_cmd_datapath
  import nor_cmd_pkg::*;
#(
  parameter logic [DATA_W-1:0] MANUF_ID = 16'h00A5,
  parameter logic [DATA_W-1:0] DEV_ID   = 16'h5A3C
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  rdmode_e           readMode,
  input  logic [7:0]        status,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0]    mem    [MEM_DEPTH];
  logic [DATA_W-1:0]    bufMem [BUF_DEPTH];
  logic [BUF_DEPTH-1:0] bufVal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_DEPTH; i++) mem[i] <= '1;
    end else if (st.progWr) begin
      mem[st.addr] <= mem[st.addr] & st.data;
    end else if (st.eraseWr) begin
      mem[st.addr] <= '1;
    end else if (st.bufCommit && bufVal[st.bufIdx]) begin
      mem[st.addr] <= mem[st.addr] & bufMem[st.bufIdx];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) bufVal <= '0;
    else if (st.bufClr) bufVal <= '0;
    else if (st.bufWr) bufVal[st.bufIdx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (st.bufWr) bufMem[st.bufIdx] <= st.data;
  end

  always_comb begin
    rdData = '0;
    case (readMode)
      RM_ARRAY:  rdData = mem[rdAddr];
      RM_STATUS: rdData = {{(DATA_W-8){1'b0}}, status};
      RM_IDENT: begin
        if (rdAddr == ADDR_W'(0))      rdData = MANUF_ID;
        else if (rdAddr == ADDR_W'(1)) rdData = DEV_ID;
      end
      RM_QUERY: begin
        if (rdAddr == ADDR_W'(16))      rdData = DATA_W'(8'h51);
        else if (rdAddr == ADDR_W'(17)) rdData = DATA_W'(8'h52);
        else if (rdAddr == ADDR_W'(18)) rdData = DATA_W'(8'h59);
      end
      default: rdData = '0;
    endcase
  end

  // R2: a program commit never raises a bit of the stored word
  a_r2_prog_clears_only: assert property (@(posedge clk) disable iff (!rstN)
    st.progWr |=> ((mem[$past(st.addr)] & ~$past(mem[st.addr])) == '0));

  // R5: a buffered commit never raises a bit of the stored word
  a_r5_buf_clears_only: assert property (@(posedge clk) disable iff (!rstN)
    st.bufCommit |=> ((mem[$past(st.addr)] & ~$past(mem[st.addr])) == '0));

  // R3: an erase step leaves the addressed word all ones
  a_r3_erase_ones: assert property (@(posedge clk) disable iff (!rstN)
    st.eraseWr |=> (mem[$past(st.addr)] == '1));

  // R2: at most one kind of array write per cycle
  a_r2_single_writer: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.progWr, st.eraseWr, st.bufCommit}));
endmodule

// File: rtl/nor_cmd_engine.sv
module nor_cmd_engine
  import nor_cmd_pkg::*;
#(
  parameter int                PROG_CYC = 6,
  parameter logic [DATA_W-1:0] MANUF_ID = 16'h00A5,
  parameter logic [DATA_W-1:0] DEV_ID   = 16'h5A3C
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [DATA_W-1:0]  rdData,
  output logic [1:0]         readMode,
  output logic [7:0]         status,
  input  logic               vppOk,
  input  logic [BLK_NUM-1:0] blockLock
);
  strobe_t stb;
  rdmode_e modeQ;

  assign readMode = modeQ;

  nor_cmd_ctrl #(.PROG_CYC(PROG_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .vppOk(vppOk), .blockLock(blockLock), .st(stb), .readMode(modeQ),
    .status(status)
  );

  nor_cmd_datapath #(.MANUF_ID(MANUF_ID), .DEV_ID(DEV_ID)) u_dp (
    .clk(clk), .rstN(rstN), .st(stb), .readMode(modeQ), .status(status),
    .rdAddr(rdAddr), .rdData(rdData)
  );
endmodule

// File: tb/nor_cmd_engine_bench.sv
module nor_cmd_engine_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [7:0]  rdAddr = '0;
  logic [15:0] rdData;
  logic [1:0]  readMode;
  logic [7:0]  status;
  logic        vppOk = 1'b1;
  logic [7:0]  blockLock = '0;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;
  logic [15:0] model [256];

  always #4 clk = ~clk;

  nor_cmd_engine u_nor_cmd_engine (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .readMode(readMode), .status(status),
    .vppOk(vppOk), .blockLock(blockLock)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitReady(input string tag);
    int n = 0;
    while (!status[7] && n < 1000) begin
      @(negedge clk);
      n++;
    end
    if (!status[7]) chk({tag, " ready timeout"}, 0, 1);
  endtask

  task automatic readWord(input logic [7:0] a, output logic [15:0] d);
    busWrite(8'h00, 16'h00FF);
    rdAddr = a;
    #1 d = rdData;
  endtask

  function automatic logic [7:0] mkAddr(input int blk, input int idx);
    return {blk[2:0], idx[4:0]};
  endfunction

  task automatic chkWord(input string tag, input logic [7:0] a);
    logic [15:0] d;
    readWord(a, d);
    chk(tag, {16'h0, d}, {16'h0, model[a]});
  endtask

  task automatic clearErr();
    busWrite(8'h00, 16'h0050);
  endtask

  initial begin
    #(8 * 190000);
    chk("watchdog expired", 0, 1);
    if (!done) begin
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    for (int i = 0; i < 256; i++) model[i] = 16'hFFFF;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 status", {24'h0, status}, 32'h80);
    chk("R1 mode", {30'h0, readMode}, 32'h0);
    rdAddr = 8'h37; #1;
    chk("R1 erased word", {16'h0, rdData}, 32'hFFFF);

    // R2 / R8 word program, busy window and AND behaviour
    busWrite(8'h00, 16'h0040);
    chk("R8 mode after program setup", {30'h0, readMode}, 32'h1);
    busWrite(8'h45, 16'h0F0F);
    chk("R2 busy after data", {31'h0, status[7]}, 32'h0);
    waitReady("R2");
    model[8'h45] = 16'h0F0F;
    chk("R2 status after program", {24'h0, status}, 32'h80);
    chkWord("R2 programmed word", 8'h45);
    busWrite(8'h00, 16'h0010);
    busWrite(8'h45, 16'hFFF0);
    waitReady("R2");
    model[8'h45] = 16'h0F00;
    chkWord("R2 ones do not restore bits", 8'h45);

    // R13 resume with nothing suspended is ignored
    busWrite(8'h00, 16'h00D0);
    chk("R13 resume ignored mode", {30'h0, readMode}, 32'h0);
    chk("R13 resume ignored status", {24'h0, status}, 32'h80);

    // R7 read modes
    busWrite(8'h00, 16'h0090);
    chk("R7 ident mode", {30'h0, readMode}, 32'h2);
    rdAddr = 8'h00; #1 chk("R7 manuf id", {16'h0, rdData}, 32'h00A5);
    rdAddr = 8'h01; #1 chk("R7 device id", {16'h0, rdData}, 32'h5A3C);
    busWrite(8'h00, 16'h0098);
    rdAddr = 8'h10; #1 chk("R7 query Q", {16'h0, rdData}, 32'h51);
    rdAddr = 8'h12; #1 chk("R7 query Y", {16'h0, rdData}, 32'h59);
    busWrite(8'h00, 16'h0070);
    #1 chk("R7 status word", {16'h0, rdData}, 32'h0080);

    // R4 erase sequence errors
    busWrite(mkAddr(1, 0), 16'h0020);
    busWrite(mkAddr(1, 0), 16'h0030);
    chk("R4 bad confirm", {24'h0, status}, 32'hB0);
    clearErr();
    chk("R10 clear when ready", {24'h0, status}, 32'h80);
    busWrite(8'h00, 16'h0040);
    busWrite(mkAddr(1, 3), 16'h1234);
    waitReady("R4");
    model[mkAddr(1, 3)] = 16'h1234;
    busWrite(mkAddr(1, 0), 16'h0020);
    busWrite(mkAddr(2, 0), 16'h00D0);
    chk("R4 wrong block", {24'h0, status}, 32'hB0);
    chkWord("R4 no erase", mkAddr(1, 3));

    // R10 / R11 clear while busy ignored; error survives success
    busWrite(8'h00, 16'h0040);
    busWrite(mkAddr(4, 1), 16'hAAAA);
    busWrite(8'h00, 16'h0050);
    waitReady("R10");
    model[mkAddr(4, 1)] = 16'hAAAA;
    chk("R10 R11 clear while busy", {24'h0, status}, 32'hB0);
    clearErr();

    // R9 voltage and lock protection
    vppOk = 1'b0;
    busWrite(8'h00, 16'h0040);
    busWrite(mkAddr(4, 2), 16'h0000);
    chk("R9 vpp program", {24'h0, status}, 32'h98);
    vppOk = 1'b1;
    clearErr();
    chkWord("R9 vpp no change", mkAddr(4, 2));
    blockLock = 8'h02;
    busWrite(mkAddr(1, 0), 16'h0020);
    busWrite(mkAddr(1, 0), 16'h00D0);
    chk("R9 lock erase", {24'h0, status}, 32'hA2);
    blockLock = 8'h00;
    clearErr();
    chkWord("R9 locked block intact", mkAddr(1, 3));

    // R3 / R14 erase, command ignored while busy
    busWrite(mkAddr(1, 7), 16'h0020);
    busWrite(mkAddr(1, 9), 16'h00D0);
    busWrite(8'h00, 16'h0090);
    chk("R14 mode held while busy", {30'h0, readMode}, 32'h1);
    waitReady("R3");
    for (int i = 0; i < 32; i++) model[mkAddr(1, i)] = 16'hFFFF;
    chkWord("R3 erased word", mkAddr(1, 3));
    chkWord("R3 neighbour block", mkAddr(4, 1));

    // R12 / R11 suspend, nested program, restricted target, resume
    busWrite(8'h00, 16'h0040);
    busWrite(mkAddr(2, 20), 16'h3C3C);
    waitReady("R12");
    model[mkAddr(2, 20)] = 16'h3C3C;
    busWrite(mkAddr(2, 0), 16'h0020);
    busWrite(mkAddr(2, 0), 16'h00D0);
    busWrite(8'h00, 16'h00B0);
    chk("R12 suspended", {24'h0, status}, 32'hC0);
    chkWord("R12 erase stopped", mkAddr(2, 20));
    busWrite(8'h00, 16'h0040);
    busWrite(mkAddr(5, 4), 16'h0101);
    waitReady("R12");
    model[mkAddr(5, 4)] = 16'h0101;
    chk("R12 program in suspend", {24'h0, status}, 32'hC0);
    chkWord("R12 other block programmed", mkAddr(5, 4));
    busWrite(8'h00, 16'h0040);
    busWrite(mkAddr(2, 21), 16'h0000);
    chk("R12 suspended block rejected", {24'h0, status}, 32'hD0);
    chkWord("R12 suspended block intact", mkAddr(2, 21));
    busWrite(8'h00, 16'h00D0);
    chk("R12 resumed busy", {31'h0, status[7]}, 32'h0);
    waitReady("R12");
    chk("R11 error kept over resume", {24'h0, status}, 32'h90);
    for (int i = 0; i < 32; i++) model[mkAddr(2, i)] = 16'hFFFF;
    chkWord("R12 erase completed", mkAddr(2, 20));
    clearErr();

    // R13 suspend during program ignored
    busWrite(8'h00, 16'h0040);
    busWrite(mkAddr(6, 6), 16'h7777);
    busWrite(8'h00, 16'h00B0);
    chk("R13 no program suspend", {31'h0, status[6]}, 32'h0);
    waitReady("R13");
    model[mkAddr(6, 6)] = 16'h7777;
    chkWord("R13 program completed", mkAddr(6, 6));

    // R5 directed buffered program with overwritten slot
    busWrite(mkAddr(3, 0), 16'h00E8);
    chk("R8 mode after buffer setup", {30'h0, readMode}, 32'h1);
    busWrite(mkAddr(3, 0), 16'h0002);
    busWrite(mkAddr(3, 5), 16'h1111);
    busWrite(mkAddr(3, 9), 16'h2222);
    busWrite(mkAddr(3, 5), 16'h4444);
    busWrite(mkAddr(3, 0), 16'h00D0);
    waitReady("R5");
    model[mkAddr(3, 5)] = 16'h4444;
    model[mkAddr(3, 9)] = 16'h2222;
    chk("R5 status", {24'h0, status}, 32'h80);
    chkWord("R5 last write wins", mkAddr(3, 5));
    chkWord("R5 second word", mkAddr(3, 9));

    // R6 buffered errors
    busWrite(mkAddr(3, 0), 16'h00E8);
    busWrite(mkAddr(3, 0), 16'd40);
    chk("R6 count too big", {24'h0, status}, 32'hB0);
    clearErr();
    busWrite(mkAddr(3, 0), 16'h00E8);
    busWrite(mkAddr(3, 0), 16'h0001);
    busWrite(mkAddr(3, 1), 16'h0000);
    busWrite(mkAddr(4, 1), 16'h0000);
    busWrite(mkAddr(3, 0), 16'h00D0);
    chk("R6 out of region", {24'h0, status}, 32'h90);
    chkWord("R6 region abort intact", mkAddr(3, 1));
    clearErr();
    busWrite(mkAddr(3, 0), 16'h00E8);
    busWrite(mkAddr(3, 0), 16'h0000);
    busWrite(mkAddr(3, 2), 16'h0000);
    busWrite(mkAddr(3, 0), 16'h0077);
    chk("R6 bad confirm", {24'h0, status}, 32'hB0);
    chkWord("R6 confirm abort intact", mkAddr(3, 2));
    clearErr();

    // Random mix of R2 / R3 / R5 operations
    for (int it = 0; it < 40; it++) begin
      int op = $urandom_range(2, 0);
      int blk = $urandom_range(7, 0);
      int idx = $urandom_range(31, 0);
      if (op == 0) begin
        logic [15:0] v = 16'($urandom);
        busWrite(8'h00, (it % 2 == 0) ? 16'h0040 : 16'h0010);
        busWrite(mkAddr(blk, idx), v);
        waitReady("R2 random");
        model[mkAddr(blk, idx)] &= v;
        chk("R2 random status", {24'h0, status}, 32'h80);
      end else if (op == 1) begin
        busWrite(mkAddr(blk, idx), 16'h0020);
        busWrite(mkAddr(blk, 31 - idx), 16'h00D0);
        waitReady("R3 random");
        for (int i = 0; i < 32; i++) model[mkAddr(blk, i)] = 16'hFFFF;
        chk("R3 random status", {24'h0, status}, 32'h80);
      end else begin
        logic [15:0] bd [32];
        bit bv [32];
        int n = $urandom_range(8, 1);
        for (int i = 0; i < 32; i++) bv[i] = 1'b0;
        busWrite(mkAddr(blk, 0), 16'h00E8);
        busWrite(mkAddr(blk, 0), 16'(n - 1));
        for (int k = 0; k < n; k++) begin
          int j = $urandom_range(31, 0);
          logic [15:0] v = 16'($urandom);
          busWrite(mkAddr(blk, j), v);
          bd[j] = v; bv[j] = 1'b1;
          idx = j;
        end
        busWrite(mkAddr(blk, 0), 16'h00D0);
        waitReady("R5 random");
        for (int i = 0; i < 32; i++) if (bv[i]) model[mkAddr(blk, i)] &= bd[i];
        chk("R5 random status", {24'h0, status}, 32'h80);
      end
      chkWord("R2 R3 R5 random touched", mkAddr(blk, idx));
      chkWord("R2 R3 R5 random other", 8'($urandom_range(255, 0)));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule